// File: doc/BRIEF.md
# Early-Terminating Sequential Integer Divider

This block computes the quotient of two 32-bit integers over several clock cycles using plain logic: one restoring shift-and-subtract step per quotient bit, with no multiplier or DSP resources. A single `is_signed` select picks two's-complement or unsigned interpretation of both operands. For signed work the block divides the magnitudes and negates the quotient when exactly one operand is negative, so the result truncates toward zero.

The divider does not always walk all 32 bit positions. Before iterating it finds the bit length of the dividend magnitude and only processes that many bits. Zero dividends and zero divisors take the one-bit short path. The iterative phase lasts 2 + 2n cycles, counting the start cycle, where n is the processed bit count (1 to 32). This gives 4 to 66 cycles. Two further pipeline cycles apply the sign and register the result, so `done` rises 2n + 4 cycles after the start cycle.

A core issues an operation by pulsing `start` while `busy` is low. It then waits for the one-cycle `done` pulse. The quotient stays on its port until the next result replaces it.

Top module: `seq_divider`

## Requirements
- R1: With `is_signed` = 0, the quotient equals floor(dividend / divisor), treating both operands as unsigned 32-bit values, for any non-zero divisor.
- R2: With `is_signed` = 1, the operands are two's complement. The quotient is the magnitude quotient, negated exactly when the operand signs differ, so it truncates toward zero.
- R3: Let n be the bit length of the dividend magnitude (the position of its highest set bit plus one), with n forced to 1 when the dividend or the divisor is zero. Then `done` is high exactly 2n + 4 cycles after the cycle in which `start` was accepted. The iteration counter stays within 1..32 while iterating.
- R4: A zero divisor yields an all-ones quotient (0xFFFFFFFF) with either `is_signed` value, after the minimum latency of 6 cycles.
- R5: A signed 0x80000000 divided by 0xFFFFFFFF (-1) yields 0x80000000.
- R6: After reset, `busy` = 0, `done` = 0 and `quotient` = 0. A `start` seen while `busy` is low is accepted and raises `busy` in the next cycle. `done` lasts one cycle, and `busy` is low in that cycle, so a new start can be accepted in the very cycle `done` is high.
- R7: A `start` seen while `busy` is high is ignored. It produces no extra result and leaves the running operation's quotient and latency unchanged.
- R8: `quotient` changes only in a cycle where `done` is high and holds its value at all other times.
- R9: A zero dividend with a non-zero divisor yields 0 after the minimum latency of 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when `busy` is low |
| is_signed | input | 1 | 1: two's-complement operands; 0: unsigned |
| dividend | input | 32 | Numerator, sampled with an accepted `start` |
| divisor | input | 32 | Denominator, sampled with an accepted `start` |
| quotient | output | 32 | Registered result, held until the next result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `quotient` holds a new result |

## Verification
The delicate coincidence is the cycle in which one result is delivered and the next operation is accepted. In that cycle `done` is high and `busy` is low, while a fresh `start` loads new operands. The scoreboard's driver waits for `busy` to drop and issues the queued operation at once, so every back-to-back pair lands a start on the done cycle. The monitor then checks that the delivered quotient belongs to the older operation and that the newer one finishes at its own computed 2n + 4 latency. The opposite collision, a `start` arriving mid-operation, is provoked by pulsing `start` with unrelated operands. It is judged by the absence of any unexpected result and by the unchanged value and timing of the running operation.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_SUB,
    ST_SEL,
    ST_SIGN,
    ST_OUT
  } div_state_e;
endpackage

// File: rtl/div_magnitude.sv
module div_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic         is_signed,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = is_signed & value[W-1];
    mag = neg ? (~value + 1'b1) : value;
  end
endmodule

// File: rtl/div_msb_finder.sv
module div_msb_finder #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] bit_len
);
  always_comb begin
    bit_len = '0;
    for (int i = 0; i < W; i++) begin
      if (value[i]) bit_len = CW'(i + 1);
    end
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [W:0]   partial,
  input  logic [W-1:0] divisor,
  output logic [W:0]   diff,
  output logic         fits
);
  logic [W+1:0] full;
  always_comb begin
    full = {1'b0, partial} - {2'b00, divisor};
    fits = ~full[W+1];
    diff = full[W:0];
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] W_C = CW'(W);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  div_state_e     state;
  logic [W-1:0]   mag_a, mag_b, mag_a_w, mag_b_w;
  logic           neg_a_w, neg_b_w, neg_q, zdiv_q;
  logic [W-1:0]   q_reg, rem_q, res_q;
  logic [W:0]     partial_q, diff_q, partial_w, diff_w;
  logic           fits_q, fits_w;
  logic [CW-1:0]  cnt, len_w, n_w;

  div_magnitude #(.W(W)) u_mag_a (
    .value(dividend), .is_signed(is_signed), .mag(mag_a_w), .neg(neg_a_w));
  div_magnitude #(.W(W)) u_mag_b (
    .value(divisor), .is_signed(is_signed), .mag(mag_b_w), .neg(neg_b_w));

  div_msb_finder #(.W(W), .CW(CW)) u_len (.value(mag_a), .bit_len(len_w));

  assign n_w = (zdiv_q || mag_a == '0) ? ONE_C : len_w;
  assign partial_w = {rem_q, q_reg[W-1]};

  div_step #(.W(W)) u_step (
    .partial(partial_w), .divisor(mag_b), .diff(diff_w), .fits(fits_w));

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mag_a     <= '0;
      mag_b     <= '0;
      neg_q     <= 1'b0;
      zdiv_q    <= 1'b0;
      q_reg     <= '0;
      rem_q     <= '0;
      res_q     <= '0;
      partial_q <= '0;
      diff_q    <= '0;
      fits_q    <= 1'b0;
      cnt       <= '0;
      quotient  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mag_a  <= mag_a_w;
          mag_b  <= mag_b_w;
          neg_q  <= neg_a_w ^ neg_b_w;
          zdiv_q <= (divisor == '0);
          state  <= ST_PREP;
        end
        ST_PREP: begin
          q_reg <= mag_a << (W_C - n_w);
          rem_q <= '0;
          cnt   <= n_w;
          state <= ST_SUB;
        end
        ST_SUB: begin
          partial_q <= partial_w;
          diff_q    <= diff_w;
          fits_q    <= fits_w;
          state     <= ST_SEL;
        end
        ST_SEL: begin
          rem_q <= fits_q ? diff_q[W-1:0] : partial_q[W-1:0];
          q_reg <= {q_reg[W-2:0], fits_q};
          cnt   <= cnt - 1'b1;
          state <= (cnt == ONE_C) ? ST_SIGN : ST_SUB;
        end
        ST_SIGN: begin
          res_q <= zdiv_q ? '1 : (neg_q ? (~q_reg + 1'b1) : q_reg);
          state <= ST_OUT;
        end
        ST_OUT: begin
          quotient <= res_q;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: done is a single-cycle pulse
  p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: busy is released in the done cycle
  p_busy_clear_at_done_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6: an idle start is accepted
  p_accept_start_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8: result port only moves with done
  p_quot_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(quotient));
  // R4: zero divisor delivers all ones
  p_zero_div_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (done && zdiv_q) |-> (quotient == '1));
  // R3: iteration count stays in range
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUB || state == ST_SEL) |-> (cnt != '0 && cnt <= W_C));
endmodule

// File: tb/seq_divider_test.sv
module seq_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic [31:0] quotient;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] exp_q_fifo[$];
  int          exp_lat_fifo[$];
  int          start_fifo[$];
  string       tag_fifo[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seq_divider uut (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .busy(busy), .done(done));

  function automatic int bit_len(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sg, input string req);
    logic [31:0] ma, mb, mq, eq;
    logic        na, nb;
    int          n;
    @(negedge clk);
    while (busy) @(negedge clk);
    na = sg & a[31];
    nb = sg & b[31];
    ma = na ? -a : a;
    mb = nb ? -b : b;
    if (b == 0) begin
      eq = 32'hFFFF_FFFF;
      n  = 1;
    end else begin
      mq = ma / mb;
      eq = (na ^ nb) ? -mq : mq;
      n  = (ma == 0) ? 1 : bit_len(ma);
    end
    exp_q_fifo.push_back(eq);
    exp_lat_fifo.push_back(2 * n + 4);
    start_fifo.push_back(cyc);
    tag_fifo.push_back(req);
    dividend  = a;
    divisor   = b;
    is_signed = sg;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q_fifo.size() == 0) begin
        check(1'b0, "R7 unexpected result", quotient, 32'h0);
      end else begin
        logic [31:0] eq;
        int          el, sc;
        string       tg;
        eq = exp_q_fifo.pop_front();
        el = exp_lat_fifo.pop_front();
        sc = start_fifo.pop_front();
        tg = tag_fifo.pop_front();
        check(quotient == eq, {tg, " quotient"}, quotient, eq);
        check((cyc - sc) == el, "R3 latency", 32'(cyc - sc), 32'(el));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R6 reset busy", {31'b0, busy}, 32'h0);
    check(done == 1'b0, "R6 reset done", {31'b0, done}, 32'h0);
    check(quotient == 32'h0, "R6 reset quotient", quotient, 32'h0);

    // unsigned cases, issued back to back (start lands on done cycle)
    run_op(32'd100, 32'd7, 1'b0, "R1");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, "R1");
    run_op(32'd1, 32'd1, 1'b0, "R1");
    run_op(32'd5, 32'd10, 1'b0, "R1");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1");
    run_op(32'h8000_0000, 32'd3, 1'b0, "R1");
    // signed truncation toward zero
    run_op(-32'sd7, 32'd2, 1'b1, "R2");
    run_op(32'd7, -32'sd2, 1'b1, "R2");
    run_op(-32'sd7, -32'sd2, 1'b1, "R2");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2");
    // most-negative over minus one
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R5");
    // zero divisor, both modes
    run_op(32'd12345, 32'd0, 1'b0, "R4");
    run_op(-32'sd9, 32'd0, 1'b1, "R4");
    // zero dividend
    run_op(32'd0, 32'd77, 1'b0, "R9");
    run_op(32'd0, -32'sd3, 1'b1, "R9");

    // R7: start pulses while busy carry other operands and must be ignored
    run_op(32'h7FFF_FFFF, 32'd13, 1'b0, "R7");
    repeat (3) @(negedge clk);
    dividend  = 32'd1;
    divisor   = 32'd0;
    is_signed = 1'b1;
    start     = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;

    // mixed patterns
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a, b;
      a = $urandom >> (k % 32);
      b = $urandom >> ((k * 7) % 32);
      run_op(a, b, k[0], k[0] ? "R2" : "R1");
    end

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q_fifo.size() == 0, "R7 outstanding results", 32'(exp_q_fifo.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule